// File: doc/BRIEF.md
# Static Memory Bank Strobe Sequencer

This block connects an internal request stream to an external asynchronous memory or peripheral bus that is split into four banks. Each accepted request names a bank, an offset inside that bank, a direction and, for writes, a data word. The block then drives a one-hot active-low chip select, an active-low output enable or write enable, the address and the outbound data. Every phase of the access lasts a number of clock cycles set separately for each bank.

Each bank stores its own settings:
- address lead time before chip select
- chip-select lead time before the strobe
- strobe length
- chip-select trail after the strobe
- address trail after chip select
- beat time for burst reads
- bus width of one or two bytes
- single-item or four-item burst reads

A plain configuration write port updates one bank per cycle. The request side is valid/ready. `req_ready` is high only while no access is running, so a request held valid waits there without loss. Read results and the end-of-access mark are single-cycle pulses with no back-pressure. The consumer must take them in the cycle they appear.

Top module: `stmem_timing_ctrl`

## Requirements
- R1: After reset all chip selects, output enable and write enable are high, data drive is off and `req_ready` is 1. Every bank's settings reset to the maximum values: 15 cycles for the 4-bit phases, 31 for the strobe field, one-byte width and single-item mode.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from the cycle after acceptance until the last cycle of the access, and a request presented meanwhile waits.
- R3: From the cycle after acceptance the offset is on `mem_addr` with all chip selects high for `tacs` cycles. A value of 0 removes this phase. The address then stays unchanged until the access ends, except for the burst steps of R7.
- R4: Chip select alone is low for `tcos` cycles before the strobe goes low. A value of 0 removes this phase.
- R5: The strobe is low for `tacc`+1 cycles. On a read, `mem_dq_i` is captured in the final cycle of the strobe.
- R6: After the strobe rises, chip select stays low for `tcoh` cycles. After chip select rises, the address stays driven for `taddr_hold` cycles. A value of 0 removes either phase.
- R7: A read on a bank in burst mode keeps chip select and output enable low for three more beats after the first. Each extra beat lasts `tacp` cycles, with 0 treated as 1. At each beat the two word-address bits advance by one modulo 4: bits [2:1] on a two-byte bank and bits [1:0] on a one-byte bank. Data is captured at the end of every beat.
- R8: On a one-byte bank, read data is returned with its upper byte forced to 0 and write data is driven as `{8'h00, wdata[7:0]}`. A two-byte bank uses all 16 bits.
- R9: A write pulses `mem_we_n` in place of `mem_oe_n` with the same phase lengths. It always makes one item, whatever the burst setting. `mem_dq_oe` is 1 from the first cycle after acceptance to the last cycle of the access. Output enable and write enable are never low together.
- R10: The chip select that goes low is bit `req_bank` of `mem_cs_n`, and at most one bit is ever low.
- R11: Settings are copied at acceptance. A configuration write during an access changes only later accesses.
- R12: `rsp_rd_valid` is high for one cycle, the cycle after each read capture, with that item on `rsp_rdata`. `rsp_done` is high for exactly one cycle, the cycle after the last phase. `rsp_done` can coincide with `rsp_rd_valid` and with `req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| cfg_valid | input | 1 | write the settings below into bank `cfg_bank` |
| cfg_bank | input | 2 | bank being configured |
| cfg_tacs | input | 4 | address lead before chip select |
| cfg_tcos | input | 4 | chip-select lead before strobe |
| cfg_tacc | input | 5 | strobe length minus one |
| cfg_tcoh | input | 4 | chip-select trail after strobe |
| cfg_taddr_hold | input | 4 | address trail after chip select |
| cfg_tacp | input | 4 | burst beat length |
| cfg_wide | input | 1 | 1 = two-byte bank |
| cfg_burst | input | 1 | 1 = four-item burst reads |
| req_valid | input | 1 | request present |
| req_ready | output | 1 | controller idle, request can be taken |
| req_write | input | 1 | 1 = write |
| req_bank | input | 2 | target bank |
| req_offset | input | 16 | offset inside the bank |
| req_wdata | input | 16 | write data |
| rsp_rd_valid | output | 1 | read item present |
| rsp_rdata | output | 16 | read item |
| rsp_done | output | 1 | access finished |
| mem_cs_n | output | 4 | chip selects, active low |
| mem_oe_n | output | 1 | output enable, active low |
| mem_we_n | output | 1 | write enable, active low |
| mem_addr | output | 16 | external address |
| mem_dq_o | output | 16 | outbound data |
| mem_dq_oe | output | 1 | outbound data drive enable |
| mem_dq_i | input | 16 | inbound data |

## Verification
Two functions can fall in the same cycle. With zero chip-select and address trails, the last read pulse and the done pulse land together, and the idle cycle that carries done also accepts the next request. The bench sets up a bank with all-zero trails in burst mode and holds a second request valid through a running access, so acceptance happens in the done cycle. A behavioural reference model checks the pins, pulses and ready on every cycle, and it flags any slip between the coinciding events.

// File: rtl/stmem_pkg.sv
package stmem_pkg;

  localparam int DATA_W  = 16;
  localparam int PHASE_W = 4;
  localparam int ACC_W   = 5;
  localparam int CNT_W   = ACC_W;

  typedef struct packed {
    logic [PHASE_W-1:0] tacs;
    logic [PHASE_W-1:0] tcos;
    logic [ACC_W-1:0]   tacc;
    logic [PHASE_W-1:0] tcoh;
    logic [PHASE_W-1:0] tah;
    logic [PHASE_W-1:0] tacp;
    logic               wide;
    logic               burst;
  } bank_cfg_t;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ASU  = 3'd1,
    PH_CSU  = 3'd2,
    PH_ACC  = 3'd3,
    PH_BEAT = 3'd4,
    PH_CSH  = 3'd5,
    PH_AH   = 3'd6
  } phase_e;

  localparam bank_cfg_t CFG_RESET = '{
    tacs: '1, tcos: '1, tacc: '1, tcoh: '1, tah: '1, tacp: '1,
    wide: 1'b0, burst: 1'b0
  };

  // First phase at or after position 'from' whose length is not zero.
  function automatic phase_e first_phase(logic [2:0] from, bank_cfg_t c, logic wr);
    if (from <= 3'd1 && c.tacs != '0) return PH_ASU;
    if (from <= 3'd2 && c.tcos != '0) return PH_CSU;
    if (from <= 3'd3)                 return PH_ACC;
    if (from <= 3'd4 && c.burst && !wr) return PH_BEAT;
    if (from <= 3'd5 && c.tcoh != '0) return PH_CSH;
    if (from <= 3'd6 && c.tah  != '0) return PH_AH;
    return PH_IDLE;
  endfunction

  // Counter load value: phase length minus one.
  function automatic logic [CNT_W-1:0] phase_load(phase_e p, bank_cfg_t c);
    case (p)
      PH_ASU:  return CNT_W'(c.tacs) - 1'b1;
      PH_CSU:  return CNT_W'(c.tcos) - 1'b1;
      PH_ACC:  return c.tacc;
      PH_BEAT: return (c.tacp == '0) ? '0 : CNT_W'(c.tacp) - 1'b1;
      PH_CSH:  return CNT_W'(c.tcoh) - 1'b1;
      PH_AH:   return CNT_W'(c.tah) - 1'b1;
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/stmem_cfg_store.sv
module stmem_cfg_store
  import stmem_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BANK_W-1:0] wr_bank,
  input  bank_cfg_t         wr_cfg,
  input  logic [BANK_W-1:0] rd_bank,
  output bank_cfg_t         rd_cfg
);

  bank_cfg_t cfg_q [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                cfg_q[b] <= CFG_RESET;
      else if (wr_en && wr_bank == BANK_W'(b))   cfg_q[b] <= wr_cfg;
    end
  end

  always_comb begin
    rd_cfg = CFG_RESET;
    for (int b = 0; b < NUM_BANKS; b++)
      if (rd_bank == BANK_W'(b)) rd_cfg = cfg_q[b];
  end

endmodule

// File: rtl/stmem_phase_seq.sv
module stmem_phase_seq
  import stmem_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  bank_cfg_t start_cfg,
  input  logic      start_write,
  output phase_e    phase,
  output logic      step,
  output logic      capture,
  output logic      done
);

  phase_e           ph_q, nxt_ph, start_ph;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       beat_q;
  bank_cfg_t        cur_cfg;
  logic             cur_wr;
  logic             done_q;
  logic             at_end;

  assign at_end   = (ph_q != PH_IDLE) && (cnt_q == '0);
  assign start_ph = first_phase(3'd1, start_cfg, start_write);

  always_comb begin
    if (ph_q == PH_BEAT && beat_q != 2'd3) nxt_ph = PH_BEAT;
    else nxt_ph = first_phase(3'(ph_q) + 3'd1, cur_cfg, cur_wr);
  end

  assign step    = at_end && (nxt_ph == PH_BEAT);
  assign capture = at_end && !cur_wr && (ph_q == PH_ACC || ph_q == PH_BEAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      beat_q  <= '0;
      cur_cfg <= CFG_RESET;
      cur_wr  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= at_end && (nxt_ph == PH_IDLE);
      if (start) begin
        // R11: settings are copied at acceptance
        ph_q    <= start_ph;
        cnt_q   <= phase_load(start_ph, start_cfg);
        cur_cfg <= start_cfg;
        cur_wr  <= start_write;
        beat_q  <= '0;
      end else if (at_end) begin
        ph_q  <= nxt_ph;
        cnt_q <= phase_load(nxt_ph, cur_cfg);
        if (step) beat_q <= beat_q + 2'd1;
      end else if (ph_q != PH_IDLE) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign phase = ph_q;
  assign done  = done_q;

  assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_burst_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (at_end && ph_q == PH_BEAT && beat_q == 2'd3) |=> (ph_q != PH_BEAT));
  assert_step_read_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (cur_cfg.burst && !cur_wr));
  assert_start_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (ph_q != PH_IDLE));

endmodule

// File: rtl/stmem_pin_drive.sv
module stmem_pin_drive
  import stmem_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int OFS_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BANK_W-1:0] start_bank,
  input  logic [OFS_W-1:0]  start_offset,
  input  logic [DATA_W-1:0] start_wdata,
  input  logic              start_write,
  input  logic              start_wide,
  input  phase_e            phase,
  input  logic              step,
  input  logic              capture,
  output logic [NUM_BANKS-1:0] cs_n,
  output logic              oe_n,
  output logic              we_n,
  output logic [OFS_W-1:0]  addr,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe,
  input  logic [DATA_W-1:0] dq_i,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rdata
);

  logic [BANK_W-1:0] bank_q;
  logic [OFS_W-1:0]  addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              wr_q, wide_q, rv_q;
  logic              cs_act, strobe_act, busy;

  assign busy       = (phase != PH_IDLE);
  assign cs_act     = (phase == PH_CSU) || (phase == PH_ACC) ||
                      (phase == PH_BEAT) || (phase == PH_CSH);
  assign strobe_act = (phase == PH_ACC) || (phase == PH_BEAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      wide_q  <= 1'b0;
      rdata_q <= '0;
      rv_q    <= 1'b0;
    end else begin
      rv_q <= capture;
      if (start) begin
        bank_q  <= start_bank;
        addr_q  <= start_offset;
        wdata_q <= start_wdata;
        wr_q    <= start_write;
        wide_q  <= start_wide;
      end else if (step) begin
        // R7: only the two word-address bits advance
        if (wide_q) addr_q[2:1] <= addr_q[2:1] + 2'd1;
        else        addr_q[1:0] <= addr_q[1:0] + 2'd1;
      end
      if (capture)
        rdata_q <= wide_q ? dq_i : {8'h00, dq_i[7:0]};
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cs
    assign cs_n[b] = !(cs_act && bank_q == BANK_W'(b));
  end

  assign oe_n     = !(strobe_act && !wr_q);
  assign we_n     = !(strobe_act && wr_q);
  assign addr     = addr_q;
  assign dq_o     = wide_q ? wdata_q : {8'h00, wdata_q[7:0]};
  assign dq_oe    = wr_q && busy;
  assign rd_valid = rv_q;
  assign rdata    = rdata_q;

  assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(step) && !$past(start)) |-> $stable(addr));
  assert_we_with_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> dq_oe);
  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));
  assert_cs_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

endmodule

// File: rtl/stmem_timing_ctrl.sv
module stmem_timing_ctrl
  import stmem_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int OFS_W     = 16,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_valid,
  input  logic [BANK_W-1:0]    cfg_bank,
  input  logic [3:0]           cfg_tacs,
  input  logic [3:0]           cfg_tcos,
  input  logic [4:0]           cfg_tacc,
  input  logic [3:0]           cfg_tcoh,
  input  logic [3:0]           cfg_taddr_hold,
  input  logic [3:0]           cfg_tacp,
  input  logic                 cfg_wide,
  input  logic                 cfg_burst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [BANK_W-1:0]    req_bank,
  input  logic [OFS_W-1:0]     req_offset,
  input  logic [15:0]          req_wdata,
  output logic                 rsp_rd_valid,
  output logic [15:0]          rsp_rdata,
  output logic                 rsp_done,
  output logic [NUM_BANKS-1:0] mem_cs_n,
  output logic                 mem_oe_n,
  output logic                 mem_we_n,
  output logic [OFS_W-1:0]     mem_addr,
  output logic [15:0]          mem_dq_o,
  output logic                 mem_dq_oe,
  input  logic [15:0]          mem_dq_i
);

  bank_cfg_t wr_cfg, sel_cfg;
  phase_e    phase;
  logic      start, step, capture;

  assign wr_cfg = '{tacs: cfg_tacs, tcos: cfg_tcos, tacc: cfg_tacc,
                    tcoh: cfg_tcoh, tah: cfg_taddr_hold, tacp: cfg_tacp,
                    wide: cfg_wide, burst: cfg_burst};

  assign req_ready = (phase == PH_IDLE);
  assign start     = req_valid && req_ready;

  stmem_cfg_store #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_valid), .wr_bank(cfg_bank),
    .wr_cfg(wr_cfg), .rd_bank(req_bank), .rd_cfg(sel_cfg)
  );

  stmem_phase_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_cfg(sel_cfg),
    .start_write(req_write), .phase(phase), .step(step),
    .capture(capture), .done(rsp_done)
  );

  stmem_pin_drive #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .OFS_W(OFS_W)) u_pins (
    .clk(clk), .rst_n(rst_n), .start(start), .start_bank(req_bank),
    .start_offset(req_offset), .start_wdata(req_wdata),
    .start_write(req_write), .start_wide(sel_cfg.wide),
    .phase(phase), .step(step), .capture(capture),
    .cs_n(mem_cs_n), .oe_n(mem_oe_n), .we_n(mem_we_n), .addr(mem_addr),
    .dq_o(mem_dq_o), .dq_oe(mem_dq_oe), .dq_i(mem_dq_i),
    .rd_valid(rsp_rd_valid), .rdata(rsp_rdata)
  );

  assert_strobe_inside_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> !(&mem_cs_n));
  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  assert_rv_needs_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_rd_valid |-> !mem_dq_oe);

endmodule

// File: tb/sim_stmem_timing_ctrl.sv
module sim_stmem_timing_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic cfg_valid = 0; logic [1:0] cfg_bank = 0;
  logic [3:0] cfg_tacs = 0, cfg_tcos = 0, cfg_tcoh = 0, cfg_tah = 0, cfg_tacp = 0;
  logic [4:0] cfg_tacc = 0; logic cfg_wide = 0, cfg_burst = 0;
  logic req_valid = 0, req_write = 0; logic [1:0] req_bank = 0;
  logic [15:0] req_offset = 0, req_wdata = 0;
  logic req_ready, rsp_rd_valid, rsp_done, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [15:0] rsp_rdata, mem_addr, mem_dq_o, mem_dq_i;
  logic [3:0] mem_cs_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] dev(logic [15:0] a);
    return {a[7:0] ^ 8'hA5, a[7:0] + 8'h3C};
  endfunction
  assign mem_dq_i = !mem_oe_n ? dev(mem_addr) : 16'hDEAD;

  stmem_timing_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_bank(cfg_bank),
    .cfg_tacs(cfg_tacs), .cfg_tcos(cfg_tcos), .cfg_tacc(cfg_tacc),
    .cfg_tcoh(cfg_tcoh), .cfg_taddr_hold(cfg_tah), .cfg_tacp(cfg_tacp),
    .cfg_wide(cfg_wide), .cfg_burst(cfg_burst), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_bank(req_bank),
    .req_offset(req_offset), .req_wdata(req_wdata), .rsp_rd_valid(rsp_rd_valid),
    .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .mem_cs_n(mem_cs_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  typedef struct {
    logic [3:0] cs_n; logic oe_n, we_n; logic [15:0] addr;
    logic dqoe; logic [15:0] dq; logic rv; logic [15:0] rd; logic dn; logic idle;
  } exp_t;
  exp_t q[$];
  bit pend_rv = 0; logic [15:0] pend_rd = 0;
  logic [15:0] last_addr = 0;

  // model settings (R1 defaults)
  int m_tacs[4] = '{15,15,15,15}, m_tcos[4] = '{15,15,15,15}, m_tacc[4] = '{31,31,31,31};
  int m_tcoh[4] = '{15,15,15,15}, m_tah[4] = '{15,15,15,15}, m_tacp[4] = '{15,15,15,15};
  bit m_wide[4] = '{0,0,0,0}, m_burst[4] = '{0,0,0,0};

  task automatic chk(string rq, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic push_e(exp_t e);
    e.rv = pend_rv; e.rd = pend_rd; pend_rv = 0;
    q.push_back(e);
  endtask

  task automatic push_access(int b, bit wr, logic [15:0] ofs, logic [15:0] wd);
    exp_t e; logic [15:0] a = ofs;
    logic [3:0] sel = ~(4'b1 << b);
    int beats = (m_burst[b] && !wr) ? 4 : 1;
    e.oe_n = 1; e.we_n = 1; e.dqoe = wr; e.dn = 0; e.idle = 0; e.rv = 0; e.rd = 0;
    e.dq = m_wide[b] ? wd : {8'h00, wd[7:0]};
    e.addr = a; e.cs_n = 4'hF;
    repeat (m_tacs[b]) push_e(e);              // R3
    e.cs_n = sel;
    repeat (m_tcos[b]) push_e(e);              // R4
    for (int k = 0; k < beats; k++) begin      // R5, R7
      int len = (k == 0) ? m_tacc[b] + 1 : ((m_tacp[b] == 0) ? 1 : m_tacp[b]);
      if (k > 0) begin
        if (m_wide[b]) a[2:1] = a[2:1] + 2'd1; else a[1:0] = a[1:0] + 2'd1;
      end
      e.addr = a; e.oe_n = wr; e.we_n = !wr;
      for (int c = 0; c < len; c++) begin
        push_e(e);
        if (c == len - 1 && !wr) begin
          pend_rv = 1; pend_rd = m_wide[b] ? dev(a) : {8'h00, dev(a)[7:0]};  // R8
        end
      end
    end
    e.oe_n = 1; e.we_n = 1;
    repeat (m_tcoh[b]) push_e(e);              // R6
    e.cs_n = 4'hF;
    repeat (m_tah[b]) push_e(e);
    e.dqoe = 0; e.dn = 1; e.idle = 1;          // R12 done cycle
    push_e(e);
  endtask

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      exp_t e;
      if (q.size() > 0) e = q.pop_front();
      else begin
        e.cs_n = 4'hF; e.oe_n = 1; e.we_n = 1; e.addr = last_addr; e.dqoe = 0;
        e.dq = 0; e.rv = pend_rv; e.rd = pend_rd; e.dn = 0; e.idle = 1; pend_rv = 0;
      end
      last_addr = e.addr;
      chk("R10 cs_n", {12'h0, mem_cs_n}, {12'h0, e.cs_n});
      chk("R4/R5 oe_n", {15'h0, mem_oe_n}, {15'h0, e.oe_n});
      chk("R9 we_n", {15'h0, mem_we_n}, {15'h0, e.we_n});
      chk("R3/R6 addr", mem_addr, e.addr);
      chk("R9 dq_oe", {15'h0, mem_dq_oe}, {15'h0, e.dqoe});
      if (e.dqoe) chk("R8/R9 dq_o", mem_dq_o, e.dq);
      chk("R2 ready", {15'h0, req_ready}, {15'h0, e.idle});
      chk("R12 done", {15'h0, rsp_done}, {15'h0, e.dn});
      chk("R12 rd_valid", {15'h0, rsp_rd_valid}, {15'h0, e.rv});
      if (e.rv) chk("R5/R7/R8 rdata", rsp_rdata, e.rd);
      if (req_valid && e.idle)
        push_access(int'(req_bank), req_write, req_offset, req_wdata);
      if (cfg_valid) begin  // R11: applies after any acceptance at this edge
        m_tacs[cfg_bank] = cfg_tacs; m_tcos[cfg_bank] = cfg_tcos;
        m_tacc[cfg_bank] = cfg_tacc; m_tcoh[cfg_bank] = cfg_tcoh;
        m_tah[cfg_bank] = cfg_tah; m_tacp[cfg_bank] = cfg_tacp;
        m_wide[cfg_bank] = cfg_wide; m_burst[cfg_bank] = cfg_burst;
      end
    end
  end

  task automatic do_cfg(int b, int s, int cs, int ac, int ch, int ah, int pp, bit w, bit br);
    @(posedge clk); #1;
    cfg_valid = 1; cfg_bank = 2'(b); cfg_tacs = 4'(s); cfg_tcos = 4'(cs);
    cfg_tacc = 5'(ac); cfg_tcoh = 4'(ch); cfg_tah = 4'(ah); cfg_tacp = 4'(pp);
    cfg_wide = w; cfg_burst = br;
    @(posedge clk); #1; cfg_valid = 0;
  endtask

  // called at posedge+1; returns at posedge+1 after acceptance
  task automatic do_req(int b, bit wr, logic [15:0] ofs, logic [15:0] wd);
    req_valid = 1; req_bank = 2'(b); req_write = wr; req_offset = ofs; req_wdata = wd;
    forever begin @(negedge clk); if (req_ready) break; end
    @(posedge clk); #1; req_valid = 0;
  endtask

  task automatic drain;
    while (q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk); #1;
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(posedge clk); #1 rst_n = 1;
    repeat (4) @(posedge clk); #1;                    // R1 idle checks
    do_req(0, 0, 16'h0123, 0); drain();               // R1 max defaults, narrow
    do_cfg(1, 2, 1, 3, 2, 1, 0, 1, 0);
    do_req(1, 0, 16'h0456, 0); drain();               // R3-R6 wide read
    do_cfg(2, 0, 0, 0, 0, 0, 0, 1, 1);
    do_req(2, 0, 16'h0A0C, 0); drain();               // R7 wrap, R12 coincidence
    do_cfg(3, 1, 2, 1, 1, 2, 3, 0, 1);
    do_req(3, 0, 16'h00F2, 0); drain();               // R7 narrow burst
    do_req(3, 1, 16'h0031, 16'hBEEF); drain();        // R9 write ignores burst, R8 narrow
    do_req(1, 1, 16'h0777, 16'h1234); drain();        // R9 wide write
    do_req(1, 0, 16'h0010, 0);                        // R2 back-to-back
    do_req(2, 0, 16'h0002, 0); drain();
    do_req(1, 0, 16'h0020, 0);                        // R11 reconfigure mid access
    do_cfg(1, 0, 0, 0, 0, 0, 0, 1, 0);
    drain();
    do_req(1, 0, 16'h0030, 0); drain();
    report();
  end
endmodule